// File: doc/BRIEF.md
# SDRAM Bank Auto-Precharge Timing Tracker

This block follows a single SDRAM bank through one open-row lifetime that ends in a write with auto precharge. A memory controller sends it two command strobes: a bank Activate, and a Write with auto precharge. It also supplies the burst-length code, the CAS latency and three timing counts: write recovery, precharge period and minimum row-active time. From these the tracker works out the cycle in which the bank's internal precharge begins. It signals that cycle with a one-clock pulse. It also raises a flag once the bank may be activated again.

The precharge cycle is the later of two points. The first is the write-recovery count after the clock that carries the final data beat. The second is the minimum row-active count after the Activate. The controller uses the busy flag to learn that the row is still open. It uses the ready flag to decide when its next Activate to this bank is legal. A command that breaks the protocol is dropped, and a sticky error flag records it.

Top module: `sdram_ap_tracker`

## Requirements
- R1: A synchronous active-high reset leaves act_ready_o high and bank_busy_o, pre_start_o and proto_err_o low.
- R2: An Activate accepted while act_ready_o is high makes bank_busy_o high and act_ready_o low from the following cycle.
- R3: burst_code_i selects 1, 2, 4 or 8 beats for codes 0, 1, 2 and 3. The last beat is (beats − 1) cycles after the Write edge.
- R4: With Activate at edge A and Write at edge W, pre_start_o is high for exactly one cycle, starting at edge P = max(W + beats − 1 + tWR, A + tRAS). bank_busy_o falls at that same edge.
- R5: When A + tRAS is later than the write-recovery point, precharge waits for A + tRAS.
- R6: act_ready_o is high from edge P + tRP − 1 onward, so an Activate is accepted at edge P + tRP at the earliest.
- R7: cas_lat_i (value 2 or 3) has no effect on any output timing.
- R8: A Write with auto precharge that arrives while the bank is idle, has a precharge pending, or is precharging sets proto_err_o. It has no other effect.
- R9: An Activate that arrives while act_ready_o is low sets proto_err_o. It has no other effect.
- R10: tRAS is sampled with the accepted Activate, and tWR and tRP are sampled with the accepted Write. Later changes on these inputs do not alter the timing.
- R11: proto_err_o stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_i | input | 1 | Activate command strobe |
| wrap_i | input | 1 | Write-with-auto-precharge command strobe |
| burst_code_i | input | 2 | Burst length code (beats = 2^code) |
| cas_lat_i | input | 2 | CAS latency, 2 or 3 |
| t_wr_i | input | 4 | Write recovery count, minimum 1 |
| t_rp_i | input | 4 | Precharge period count, minimum 1 |
| t_ras_i | input | 4 | Minimum row-active count, minimum 1 |
| pre_start_o | output | 1 | One-cycle pulse when internal precharge begins |
| bank_busy_o | output | 1 | Row open (active or precharge pending) |
| act_ready_o | output | 1 | Next Activate allowed |
| proto_err_o | output | 1 | Sticky protocol error |

## Verification
All timing is measured from the Activate edge A. bank_busy_o is due one register after A. pre_start_o is due exactly at edge P = max(W + beats − 1 + tWR, A + tRAS). act_ready_o is due at edge P + tRP − 1. The bench works out P for each configuration, then samples all outputs on the falling edge after each rising edge A + e. It compares them cycle by cycle against these closed-form windows. This covers every burst code, both CAS latencies, a spread of timing counts and two Activate-to-Write gaps. The timing inputs are scrambled once each command has been accepted, which exercises R10.

// File: rtl/sdram_ap_pkg.sv
package sdram_ap_pkg;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_ACTIVE = 2'd1,
    BK_PEND   = 2'd2,
    BK_PRECH  = 2'd3
  } bank_state_e;

  // Offset in cycles from the Write edge to the last data beat.
  function automatic int unsigned last_beat_ofs(input logic [1:0] code);
    return (32'd1 << code) - 32'd1;
  endfunction

  // Cycles from Write edge to the earliest write-recovery precharge point.
  function automatic int unsigned wr_recovery_span(input logic [1:0] code,
                                                    input int unsigned twr);
    return last_beat_ofs(code) + twr;
  endfunction

endpackage

// File: rtl/ap_window_cnt.sv
// Saturating down-counter: done is high once the loaded window has elapsed
// at the edge that observes it.
module ap_window_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q <= W'(1));

  // R4: all windows have a minimum length of one cycle
  a_r4_min_window: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0));

  // R4: a freshly loaded window longer than one cycle is not yet done
  a_r4_load_pending: assert property (@(posedge clk) disable iff (rst)
    (load && load_val > W'(1)) |=> !done);
endmodule

// File: rtl/ap_bank_fsm.sv
module ap_bank_fsm
  import sdram_ap_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_i,
  input  logic          wrap_i,
  input  logic [TW-1:0] t_rp_i,
  input  logic          ras_done,
  input  logic          wr_done,
  input  logic          rp_done,
  output logic          act_acc,
  output logic          wr_acc,
  output logic          pre_fire,
  output logic [TW-1:0] rp_load_val,
  output logic          pre_start_o,
  output logic          bank_busy_o,
  output logic          act_ready_o,
  output logic          proto_err_o
);
  bank_state_e state_q, state_d;
  logic [TW-1:0] rp_q;
  logic          pre_q, err_q, err_set;

  always_comb begin
    act_ready_o = (state_q == BK_IDLE) || (state_q == BK_PRECH && rp_done);
    act_acc     = act_i && act_ready_o;
    wr_acc      = wrap_i && (state_q == BK_ACTIVE);
    pre_fire    = (state_q == BK_PEND) && ras_done && wr_done;
    err_set     = (act_i && !act_ready_o) || (wrap_i && state_q != BK_ACTIVE);
    bank_busy_o = (state_q == BK_ACTIVE) || (state_q == BK_PEND);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BK_IDLE:   if (act_acc)  state_d = BK_ACTIVE;
      BK_ACTIVE: if (wr_acc)   state_d = BK_PEND;
      BK_PEND:   if (pre_fire) state_d = BK_PRECH;
      BK_PRECH: begin
        if (act_acc)      state_d = BK_ACTIVE;
        else if (rp_done) state_d = BK_IDLE;
      end
      default:            state_d = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BK_IDLE;
      rp_q    <= '0;
      pre_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pre_q   <= pre_fire;
      if (wr_acc)  rp_q  <= t_rp_i;
      if (err_set) err_q <= 1'b1;
    end
  end

  assign rp_load_val = rp_q;
  assign pre_start_o = pre_q;
  assign proto_err_o = err_q;

  // R8: a write that is refused leaves the open/closed state of the row alone
  a_r8_bad_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wrap_i && state_q == BK_IDLE && !act_i) |=> (state_q == BK_IDLE));

  // R9: a refused Activate never opens a row
  a_r9_bad_act_ignored: assert property (@(posedge clk) disable iff (rst)
    (act_i && !act_ready_o && state_q == BK_PRECH) |=> (state_q != BK_ACTIVE));

  // R4: precharge starts only out of a pending auto-precharge
  a_r4_fire_from_pend: assert property (@(posedge clk) disable iff (rst)
    pre_start_o |-> $past(state_q == BK_PEND));
endmodule

// File: rtl/sdram_ap_tracker.sv
module sdram_ap_tracker
  import sdram_ap_pkg::*;
#(
  parameter int TW  = 4,
  parameter int BCW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           act_i,
  input  logic           wrap_i,
  input  logic [BCW-1:0] burst_code_i,
  input  logic [1:0]     cas_lat_i,
  input  logic [TW-1:0]  t_wr_i,
  input  logic [TW-1:0]  t_rp_i,
  input  logic [TW-1:0]  t_ras_i,
  output logic           pre_start_o,
  output logic           bank_busy_o,
  output logic           act_ready_o,
  output logic           proto_err_o
);
  localparam int MAXBEAT = (1 << ((1 << BCW) - 1)) - 1;
  localparam int WRW     = $clog2((1 << TW) + MAXBEAT);

  logic           act_acc, wr_acc, pre_fire;
  logic           ras_done, wr_done, rp_done;
  logic [TW-1:0]  rp_load_val;
  logic [WRW-1:0] wr_load_val;

  assign wr_load_val = WRW'(wr_recovery_span(2'(burst_code_i), 32'(t_wr_i)));

  ap_window_cnt #(.W(TW)) u_ras_cnt (
    .clk(clk), .rst(rst), .load(act_acc), .load_val(t_ras_i), .done(ras_done));

  ap_window_cnt #(.W(WRW)) u_wr_cnt (
    .clk(clk), .rst(rst), .load(wr_acc), .load_val(wr_load_val), .done(wr_done));

  ap_window_cnt #(.W(TW)) u_rp_cnt (
    .clk(clk), .rst(rst), .load(pre_fire), .load_val(rp_load_val), .done(rp_done));

  ap_bank_fsm #(.TW(TW)) u_fsm (
    .clk(clk), .rst(rst), .act_i(act_i), .wrap_i(wrap_i), .t_rp_i(t_rp_i),
    .ras_done(ras_done), .wr_done(wr_done), .rp_done(rp_done),
    .act_acc(act_acc), .wr_acc(wr_acc), .pre_fire(pre_fire),
    .rp_load_val(rp_load_val), .pre_start_o(pre_start_o),
    .bank_busy_o(bank_busy_o), .act_ready_o(act_ready_o),
    .proto_err_o(proto_err_o));

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (act_ready_o && !bank_busy_o && !pre_start_o && !proto_err_o));

  // R4: precharge start is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pre_start_o |=> !pre_start_o);

  // R4: the row closes on the precharge edge
  a_r4_busy_drops: assert property (@(posedge clk) disable iff (rst)
    pre_start_o |-> (!bank_busy_o && $past(bank_busy_o)));

  // R2: an open row is never reported ready for Activate
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    !(bank_busy_o && act_ready_o));

  // R7: only latencies 2 and 3 are legal with a write
  a_r7_cas_legal: assert property (@(posedge clk) disable iff (rst)
    wrap_i |-> (cas_lat_i == 2'd2 || cas_lat_i == 2'd3));

  // R11: error flag is sticky
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
    proto_err_o |=> proto_err_o);
endmodule

// File: tb/sdram_ap_tracker_tb.sv
module sdram_ap_tracker_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       act_i = 1'b0, wrap_i = 1'b0;
  logic [1:0] burst_code_i = '0, cas_lat_i = 2'd2;
  logic [3:0] t_wr_i = 4'd1, t_rp_i = 4'd1, t_ras_i = 4'd1;
  logic       pre_start_o, bank_busy_o, act_ready_o, proto_err_o;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;   // 125 MHz

  sdram_ap_tracker u_dut (
    .clk(clk), .rst(rst), .act_i(act_i), .wrap_i(wrap_i),
    .burst_code_i(burst_code_i), .cas_lat_i(cas_lat_i),
    .t_wr_i(t_wr_i), .t_rp_i(t_rp_i), .t_ras_i(t_ras_i),
    .pre_start_o(pre_start_o), .bank_busy_o(bank_busy_o),
    .act_ready_o(act_ready_o), .proto_err_o(proto_err_o));

  task automatic chk(input string req, input int actual, input int expected);
    nchk++;
    if (actual != expected) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, actual, expected, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; act_i = 1'b0; wrap_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 ready", act_ready_o, 1);
    chk("R1 busy", bank_busy_o, 0);
    chk("R1 pre", pre_start_o, 0);
    chk("R1 err", proto_err_o, 0);
  endtask

  // One Activate / Write-AP cycle. Outputs are sampled at the falling edge
  // after rising edge A+e. xact / xwr inject an illegal extra command
  // (driven after sample e, so seen at edge A+e+1); -1 means none.
  task automatic run(input int code, input int cl, input int twr, input int trp,
                     input int tras, input int gap, input int xact, input int xwr);
    int beats = 1 << code;
    int wrpt  = gap + beats - 1 + twr;
    int p     = (wrpt > tras) ? wrpt : tras;
    int last  = p + trp + 1;
    bit experr = (xact >= 0) || (xwr >= 0);
    string ptag;
    ptag = (tras > wrpt) ? "R5" : ((code != 0) ? "R3 R4" : "R4");
    ptag = {ptag, " R10", (cl == 3) ? " R7" : ""};
    @(negedge clk);
    act_i = 1'b1; t_ras_i = 4'(tras); burst_code_i = 2'(code); cas_lat_i = 2'(cl);
    for (int e = 0; e <= last; e++) begin
      @(negedge clk);
      act_i = 1'b0; wrap_i = 1'b0;
      t_ras_i = 4'(~tras);
      t_wr_i  = 4'(~twr);
      t_rp_i  = 4'(~trp);
      chk(ptag, pre_start_o, (e == p) ? 1 : 0);
      chk("R2 busy", bank_busy_o, (e < p) ? 1 : 0);
      chk("R6 ready", act_ready_o, (e >= p + trp - 1) ? 1 : 0);
      if (e == gap - 1) begin
        wrap_i = 1'b1; t_wr_i = 4'(twr); t_rp_i = 4'(trp);
      end
      if (e == xact) act_i = 1'b1;
      if (e == xwr)  wrap_i = 1'b1;
    end
    chk(xact >= 0 ? "R9 err" : "R8 err", proto_err_o, experr ? 1 : 0);
    if (experr) do_reset();
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int twr_l[4]  = '{1, 2, 5, 15};
    int trp_l[3]  = '{1, 2, 7};
    int tras_l[4] = '{1, 3, 8, 15};
    int gap_l[2]  = '{1, 4};
    do_reset();
    for (int c = 0; c < 4; c++)
      for (int cl = 2; cl <= 3; cl++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 3; b++)
            for (int r = 0; r < 4; r++)
              for (int g = 0; g < 2; g++)
                run(c, cl, twr_l[a], trp_l[b], tras_l[r], gap_l[g], -1, -1);

    // R8: write with auto precharge while idle
    @(negedge clk);
    wrap_i = 1'b1;
    @(negedge clk);
    wrap_i = 1'b0;
    chk("R8 err idle", proto_err_o, 1);
    chk("R8 busy idle", bank_busy_o, 0);
    chk("R8 ready idle", act_ready_o, 1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R8 no pre", pre_start_o, 0);
      chk("R11 sticky", proto_err_o, 1);
    end
    do_reset();
    chk("R11 cleared", proto_err_o, 0);

    run(2, 3, 3, 2, 10, 2, 3, -1);  // R9: Activate while row pending
    run(1, 2, 2, 3, 1, 1, -1, 2);   // R8: second write while pending
    run(0, 2, 1, 3, 1, 1, -1, 2);   // R8: write while precharging
    run(0, 2, 1, 4, 1, 1, 3, -1);   // R9: Activate before tRP elapsed
    run(3, 3, 15, 15, 15, 4, -1, -1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule